// File: doc/BRIEF.md
# Quad PLL Control and Sticky-Status Register

This block is a single 32-bit control and status word for up to four transceiver quad PLLs. Each PLL owns one 4-bit field. The field holds the PLL's reset control, its live lock indication, and two sticky alarms. One alarm records that lock was lost. The other records that the reference clock went away. Software writes the word to hold or release each PLL's reset. It reads the word back to see lock state and alarms.

Setting a single strobe bit in a write clears every alarm at once. That bit never holds a value.

The lock and reference-present inputs come from the PLLs, which run asynchronously to the register clock. Each passes through a two-flop synchronizer before it is shown or edge-detected. An alarm sets only on a falling edge of the synchronized signal. A PLL that has never locked therefore raises no alarm.

Top module: `pll_ctl_status_reg`

## Requirements
- R1: PLL n (n = 0..3) occupies readback bits [4n+3:4n]; a write's bit 4n controls only pll_rst[n].
- R2: Field bit 0 is the reset control (1 = PLL held in reset); a write updates pll_rst[n] and readback bit 4n on the clock edge that takes the write.
- R3: Field bit 1 shows pll_lock[n] after a two-flop synchronizer, so a change on the input reaches the readback two clock edges later.
- R4: Field bit 2 sets on a falling edge of synchronized lock and stays set, even if lock returns, until it is cleared.
- R5: Field bit 3 sets on a falling edge of synchronized pll_refclk_ok and stays set until it is cleared.
- R6: A rising edge or a steady level on lock or reference-present never sets a sticky bit.
- R7: A write with bit 16 set clears all sticky bits of all PLLs on that edge; bit 16 always reads back as 0.
- R8: After reset, every PLL is held in reset, so pll_rst is all ones and the readback reset bits form 0x1111, with no sticky bit set.
- R9: Write data in field bits 1 to 3 and in bits 31:17 has no effect; readback bits 31:16 are always 0.
- R10: When a sticky event and a clear strobe fall on the same clock edge, the event wins and that sticky bit is set after the edge.
- R11: A PLL that is out of reset, locked, with its reference present and no alarm reads back its field as 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data: reset bits at 4n, clear-all strobe at bit 16 |
| rd_data | output | 32 | Readback word, one 4-bit field per PLL |
| pll_lock | input | 4 | Per-PLL lock indication, asynchronous |
| pll_refclk_ok | input | 4 | Per-PLL reference clock present, asynchronous |
| pll_rst | output | 4 | Per-PLL reset, 1 = held in reset |

## Verification
The assertions assume two things about the PLL inputs. Each level holds for at least one register clock. Each edge lands in the synchronizer's first stage before the edge detector compares the last two stages. With that assumption, one input transition produces exactly one detected edge.

The bench drives inputs only on falling clock edges. It waits several cycles after every input change before it reads or writes. The one exception is the collision scenario, which places a lock drop exactly three edges ahead of a clear strobe so that both resolve on the same edge.

// File: rtl/pllcs_pkg.sv
// Package: field layout shared by the PLL control/status register.
// Assumes at most four PLLs so that all fields sit below the clear strobe.
package pllcs_pkg;
    localparam int FIELD_W   = 4;
    localparam int CLR_BIT   = 16;
    localparam int MAX_PLL   = CLR_BIT / FIELD_W;

    // One PLL field, most significant bit first.
    typedef struct packed {
        logic lost_ref;   // sticky: reference clock went away
        logic lost_lock;  // sticky: lock dropped
        logic locked;     // live, synchronized lock
        logic in_reset;   // reset control
    } pll_field_t;
endpackage

// File: rtl/pllcs_sync.sv
// Module: multi-stage synchronizer bank for asynchronous level inputs.
// Assumes inputs hold each level for at least one clock; reset clears all stages.
module pllcs_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

    // R3
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(pipe[STAGES-2])));
endmodule

// File: rtl/pllcs_channel.sv
// Module: one PLL's field: reset control, live lock and two sticky alarms.
// Assumes lock_s/ref_s are already synchronized to clk.
module pllcs_channel
    import pllcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_rst,
    input  logic       clr_all,
    input  logic       lock_s,
    input  logic       ref_s,
    output logic       rst_q,
    output pll_field_t field
);
    logic lock_d, ref_d;
    logic stk_lock, stk_ref;
    logic lock_fall, ref_fall;

    assign lock_fall = lock_d & ~lock_s;
    assign ref_fall  = ref_d & ~ref_s;

    // Reset control bit, written directly by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     rst_q <= 1'b1;
        else if (wr_en) rst_q <= wr_rst;
    end

    // Delayed copies for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_d <= 1'b0;
            ref_d  <= 1'b0;
        end else begin
            lock_d <= lock_s;
            ref_d  <= ref_s;
        end
    end

    // Sticky alarms: an event has priority over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_lock <= 1'b0;
            stk_ref  <= 1'b0;
        end else begin
            if (lock_fall)    stk_lock <= 1'b1;
            else if (clr_all) stk_lock <= 1'b0;
            if (ref_fall)     stk_ref  <= 1'b1;
            else if (clr_all) stk_ref  <= 1'b0;
        end
    end

    assign field = '{lost_ref: stk_ref, lost_lock: stk_lock,
                     locked: lock_s, in_reset: rst_q};

    // R2
    rst_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rst_q == $past(wr_rst)));
    // R4
    lock_loss_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_d && !lock_s) |=> field.lost_lock);
    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field.lost_lock && !clr_all) |=> field.lost_lock);
    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!field.lost_ref && !(ref_d && !ref_s)) |=> !field.lost_ref);
    // R7
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !(ref_d && !ref_s)) |=> !field.lost_ref);
    // R10
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && lock_d && !lock_s) |=> field.lost_lock);
endmodule

// File: rtl/pll_ctl_status_reg.sv
// Module: top of the quad PLL control/status register.
// Assumes one-cycle write strobes; readback is combinational from register state.
module pll_ctl_status_reg
    import pllcs_pkg::*;
#(
    parameter int NUM_PLL     = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_PLL-1:0] pll_lock,
    input  logic [NUM_PLL-1:0] pll_refclk_ok,
    output logic [NUM_PLL-1:0] pll_rst
);
    localparam int SYNC_W = 2 * NUM_PLL;

    // Write bits that carry meaning: one reset bit per PLL plus the clear strobe.
    function automatic logic [DATA_W-1:0] used_mask();
        logic [DATA_W-1:0] m = '0;
        for (int n = 0; n < NUM_PLL; n++) m[n*FIELD_W] = 1'b1;
        m[CLR_BIT] = 1'b1;
        return m;
    endfunction
    localparam logic [DATA_W-1:0] USED_MASK = used_mask();

    logic [SYNC_W-1:0] sync_q;
    logic              clr_all;
    logic              unused_wr_bits;
    pll_field_t        fields [NUM_PLL];

    assign clr_all        = wr_en & wr_data[CLR_BIT];
    assign unused_wr_bits = ^(wr_data & ~USED_MASK);

    pllcs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pll_refclk_ok, pll_lock}),
        .q     (sync_q)
    );

    for (genvar n = 0; n < NUM_PLL; n++) begin : g_pll
        pllcs_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_rst  (wr_data[n*FIELD_W]),
            .clr_all (clr_all),
            .lock_s  (sync_q[n]),
            .ref_s   (sync_q[NUM_PLL+n]),
            .rst_q   (pll_rst[n]),
            .field   (fields[n])
        );
    end

    // Pack the per-PLL fields into the readback word.
    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NUM_PLL; n++) rd_data[n*FIELD_W +: FIELD_W] = fields[n];
    end

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[DATA_W-1:CLR_BIT] == '0));
endmodule

// File: tb/sim_pll_ctl_status_reg.sv
module sim_pll_ctl_status_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  pll_lock = '0;
    logic [3:0]  pll_refclk_ok = '0;
    logic [3:0]  pll_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the register
    logic [3:0] m_rst = 4'hF;
    logic [3:0] m_stk_lock = '0;
    logic [3:0] m_stk_ref = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_ctl_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pll_lock(pll_lock), .pll_refclk_ok(pll_refclk_ok),
        .pll_rst(pll_rst)
    );

    function automatic logic [31:0] model_rd();
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++)
            v[4*n +: 4] = {m_stk_ref[n], m_stk_lock[n], pll_lock[n], m_rst[n]};
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, rd_data, model_rd());
        check(req, {28'd0, pll_rst}, {28'd0, m_rst});
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        for (int n = 0; n < 4; n++) m_rst[n] = d[4*n];
        if (d[16]) begin m_stk_lock = '0; m_stk_ref = '0; end
    endtask

    task automatic set_inputs(input logic [3:0] lk, input logic [3:0] rf);
        @(negedge clk);
        m_stk_lock |= pll_lock & ~lk;
        m_stk_ref  |= pll_refclk_ok & ~rf;
        pll_lock = lk; pll_refclk_ok = rf;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R8", rd_data, 32'h0000_1111);
        check("R8", {28'd0, pll_rst}, 32'hF);
    endtask

    task automatic t_rise_no_flag();
        set_inputs(4'hF, 4'hF);
        check("R6", rd_data, 32'h0000_3333);
        check_all("R3");
    endtask

    task automatic t_lock_latency();
        @(negedge clk);
        pll_lock = 4'hE;                       // drop PLL0 lock
        m_stk_lock[0] = 1'b1;
        @(negedge clk);                        // one edge: not yet visible
        check("R3", {31'd0, rd_data[1]}, 32'd1);
        @(negedge clk);                        // two edges: visible
        check("R3", {31'd0, rd_data[1]}, 32'd0);
        repeat (3) @(negedge clk);
        check("R4", {31'd0, rd_data[2]}, 32'd1);
        set_inputs(4'hF, 4'hF);
        wr(32'h0001_1111);                     // clear
        check_all("R7");
    endtask

    task automatic t_release();
        wr(32'h0000_0000);
        check("R11", rd_data, 32'h0000_2222);
        check("R2", {28'd0, pll_rst}, 32'h0);
    endtask

    task automatic t_layout();
        wr(32'h0000_0100);
        check("R1", rd_data, 32'h0000_2322);
        check("R1", {28'd0, pll_rst}, 32'h4);
    endtask

    task automatic t_lock_loss();
        set_inputs(4'hD, 4'hF);
        check("R4", rd_data, 32'h0000_2342);
        set_inputs(4'hF, 4'hF);                // relock: alarm stays
        check("R4", rd_data, 32'h0000_2362);
        repeat (10) @(negedge clk);
        check_all("R4");
    endtask

    task automatic t_ref_loss();
        set_inputs(4'hF, 4'h7);
        check("R5", rd_data, 32'h0000_A362);
        set_inputs(4'hF, 4'hF);
        check_all("R5");
    endtask

    task automatic t_ignore();
        wr(32'hFFFE_EEEF);
        check("R9", rd_data, 32'h0000_A263);
        check("R9", {28'd0, pll_rst}, 32'h1);
        check_all("R9");
    endtask

    task automatic t_clear();
        wr(32'h0001_0000);
        check("R7", rd_data, 32'h0000_2222);
        check("R7", {31'd0, rd_data[16]}, 32'd0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        pll_lock = 4'hB;                       // drop PLL2 lock before edge e1
        pll_refclk_ok = 4'hF;
        @(negedge clk);                        // after e1
        @(negedge clk);                        // after e2
        wr_en = 1'b1; wr_data = 32'h0001_0000; // clear lands on e3 with the event
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        m_rst = 4'h0; m_stk_lock = 4'h4; m_stk_ref = '0;
        check("R10", {31'd0, rd_data[10]}, 32'd1);
        repeat (3) @(negedge clk);
        check_all("R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise_no_flag();
        t_lock_latency();
        t_release();
        t_layout();
        t_lock_loss();
        t_ref_loss();
        t_ignore();
        t_clear();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule